// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block puts a serial test register between the core logic and a small group of bidirectional port pins. Each pin carries four scan cells: one observes the level on the pin, and three hold the values the core would drive (output data, output enable and pull-up disable). All the cells form one shift path from `tdi` to `tdo`. Each cell has a capture/shift flip-flop on the rising test clock and an update latch that loads on the falling test clock.

An external TAP controller drives the shift, capture and update enables and the two-bit mode. In the functional modes the core owns the pins. In sample/preload mode the chain takes snapshots and can preload the update latches while the pins still follow the core. In external-test mode the pins take their values from the update latches at once, and the core input is held at the latched input-cell value.

Top module: `bsr_chain`

## Requirements
- R1: The chain has 4*NPINS cells. With `shift_en` high and `capture_en` low on a rising `tck`, `tdi` enters the first cell, every cell takes the value of its predecessor, and `tdo` shows the last cell.
- R2: Cell order from `tdi`: for each pin, input data (kind 0), output data (kind 1), output enable (kind 2), pull-up disable (kind 3). Pins go from the highest index to the lowest, so pin p kind k sits at position (NPINS-1-p)*4+k and position 0 is next to `tdi`.
- R3: With `capture_en` high on a rising `tck`, input cells load `pin_in` and the other cells load `core_out`, `core_oe` and `core_pud`. Capture takes priority over shift when both enables are high.
- R4: With neither `shift_en` nor `capture_en` high, the chain contents and `tdo` hold.
- R5: With `update_en` high on a falling `tck`, every update latch copies its cell's flip-flop. The update latches hold otherwise, in every mode.
- R6: Mode encoding is 2'b00 functional, 2'b01 sample/preload, 2'b10 external test and 2'b11 functional. In every mode except external test, `pin_out`, `pin_oe` and `pin_pud` equal the core signals and `core_in` equals `pin_in`.
- R7: In external-test mode, `pin_out`, `pin_oe` and `pin_pud` equal the update latches of the kind 1, 2 and 3 cells, and `core_in` equals the latch of the kind 0 cell. This holds as soon as the mode is selected, with no shift or update needed.
- R8: A low `rst_n` clears the chain and the update latches at once, so no pin is enabled in external test after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data into the chain |
| tdo | output | 1 | Serial data out of the last cell |
| shift_en | input | 1 | Shift the chain one position |
| capture_en | input | 1 | Parallel capture into the chain |
| update_en | input | 1 | Load the update latches on the falling clock |
| mode | input | 2 | Operating mode |
| core_out | input | NPINS | Core output data |
| core_oe | input | NPINS | Core output enable |
| core_pud | input | NPINS | Core pull-up disable |
| core_in | output | NPINS | Input level presented to the core |
| pin_in | input | NPINS | Level observed at each pin |
| pin_out | output | NPINS | Data driven toward each pin |
| pin_oe | output | NPINS | Output enable toward each pin |
| pin_pud | output | NPINS | Pull-up disable toward each pin |

## Verification
Shift and update can fall in the same bench cycle. The falling-edge update then loads the chain as it stood before that cycle's rising-edge shift. The random phase sets both enables together often, and the bench model applies the update before the shift, so any wrong ordering shows up on the pins once external test is selected. Capture and shift asserted together are also provoked, and the result is judged against a capture-only model.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int CELLS_PER_PIN = 4;

  typedef enum logic [1:0] {
    KIND_IN   = 2'd0,
    KIND_DOUT = 2'd1,
    KIND_OE   = 2'd2,
    KIND_PUD  = 2'd3
  } cell_kind_e;

  typedef enum logic [1:0] {
    MODE_FUNC     = 2'b00,
    MODE_SAMPLE   = 2'b01,
    MODE_EXTEST   = 2'b10,
    MODE_FUNC_ALT = 2'b11
  } scan_mode_e;

  function automatic int cell_pos(int npins, int pin, int kind);
    return (npins - 1 - pin) * CELLS_PER_PIN + kind;
  endfunction

  function automatic logic cap_select(int kind, logic v_in, logic v_dout,
                                      logic v_oe, logic v_pud);
    case (kind)
      0:       return v_in;
      1:       return v_dout;
      2:       return v_oe;
      default: return v_pud;
    endcase
  endfunction
endpackage

// File: rtl/bsr_cell.sv
module bsr_cell (
  input  logic tck,
  input  logic rst_n,
  input  logic shift_en,
  input  logic capture_en,
  input  logic update_en,
  input  logic si,
  input  logic cap_d,
  output logic so,
  output logic upd_q
);
  logic stage_q;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)          stage_q <= 1'b0;
    else if (capture_en) stage_q <= cap_d;
    else if (shift_en)   stage_q <= si;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)         upd_q <= 1'b0;
    else if (update_en) upd_q <= stage_q;
  end

  assign so = stage_q;
endmodule

// File: rtl/bsr_pin_mux.sv
module bsr_pin_mux (
  input  logic ext_on,
  input  logic core_out,
  input  logic core_oe,
  input  logic core_pud,
  input  logic pin_in,
  input  logic lat_in,
  input  logic lat_dout,
  input  logic lat_oe,
  input  logic lat_pud,
  output logic pin_out,
  output logic pin_oe,
  output logic pin_pud,
  output logic core_in
);
  always_comb begin
    if (ext_on) begin
      pin_out = lat_dout;
      pin_oe  = lat_oe;
      pin_pud = lat_pud;
      core_in = lat_in;
    end else begin
      pin_out = core_out;
      pin_oe  = core_oe;
      pin_pud = core_pud;
      core_in = pin_in;
    end
  end
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain #(
  parameter int NPINS = 4
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             tdi,
  output logic             tdo,
  input  logic             shift_en,
  input  logic             capture_en,
  input  logic             update_en,
  input  logic [1:0]       mode,
  input  logic [NPINS-1:0] core_out,
  input  logic [NPINS-1:0] core_oe,
  input  logic [NPINS-1:0] core_pud,
  output logic [NPINS-1:0] core_in,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_pud
);
  import bsr_pkg::*;

  localparam int LEN = NPINS * CELLS_PER_PIN;

  logic [LEN-1:0] chain_q;
  logic [LEN-1:0] upd_q;
  logic [LEN-1:0] cap_vec;
  logic [LEN-1:0] shift_src;
  logic           extest_on;

  assign extest_on = (mode == MODE_EXTEST);
  assign shift_src = {chain_q[LEN-2:0], tdi};
  assign tdo       = chain_q[LEN-1];

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    for (genvar k = 0; k < CELLS_PER_PIN; k++) begin : g_cell
      localparam int POS = cell_pos(NPINS, p, k);
      assign cap_vec[POS] = cap_select(k, pin_in[p], core_out[p],
                                       core_oe[p], core_pud[p]);
      bsr_cell cell_i (
        .tck       (tck),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .capture_en(capture_en),
        .update_en (update_en),
        .si        (shift_src[POS]),
        .cap_d     (cap_vec[POS]),
        .so        (chain_q[POS]),
        .upd_q     (upd_q[POS])
      );
    end

    bsr_pin_mux mux_i (
      .ext_on  (extest_on),
      .core_out(core_out[p]),
      .core_oe (core_oe[p]),
      .core_pud(core_pud[p]),
      .pin_in  (pin_in[p]),
      .lat_in  (upd_q[cell_pos(NPINS, p, 0)]),
      .lat_dout(upd_q[cell_pos(NPINS, p, 1)]),
      .lat_oe  (upd_q[cell_pos(NPINS, p, 2)]),
      .lat_pud (upd_q[cell_pos(NPINS, p, 3)]),
      .pin_out (pin_out[p]),
      .pin_oe  (pin_oe[p]),
      .pin_pud (pin_pud[p]),
      .core_in (core_in[p])
    );
  end
endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk #(
  parameter int NPINS = 4
) (
  input logic             tck,
  input logic             rst_n,
  input logic             tdi,
  input logic             shift_en,
  input logic             capture_en,
  input logic             update_en,
  input logic             extest_on,
  input logic [NPINS-1:0] core_out,
  input logic [NPINS-1:0] core_oe,
  input logic [NPINS-1:0] core_pud,
  input logic [NPINS-1:0] core_in,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] pin_pud,
  input logic [NPINS*4-1:0] chain_q,
  input logic [NPINS*4-1:0] upd_q
);
  import bsr_pkg::*;
  localparam int LEN = NPINS * CELLS_PER_PIN;

  assert_shift_R1: assert property (@(posedge tck) disable iff (!rst_n)
    (shift_en && !capture_en) |=> chain_q == {$past(chain_q[LEN-2:0]), $past(tdi)});

  assert_hold_R4: assert property (@(posedge tck) disable iff (!rst_n)
    (!shift_en && !capture_en) |=> $stable(chain_q));

  assert_update_R5: assert property (@(negedge tck) disable iff (!rst_n)
    update_en |=> upd_q == $past(chain_q));

  assert_keep_R5: assert property (@(negedge tck) disable iff (!rst_n)
    !update_en |=> $stable(upd_q));

  always @(posedge tck) begin
    if (!rst_n) assert_reset_R8: assert ((upd_q == '0) && (chain_q == '0));
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_p
    localparam int PI = cell_pos(NPINS, p, 0);
    localparam int PD = cell_pos(NPINS, p, 1);
    localparam int PE = cell_pos(NPINS, p, 2);
    localparam int PU = cell_pos(NPINS, p, 3);

    assert_capture_R3: assert property (@(posedge tck) disable iff (!rst_n)
      capture_en |=> (chain_q[PI] == $past(pin_in[p])) &&
                     (chain_q[PD] == $past(core_out[p])) &&
                     (chain_q[PE] == $past(core_oe[p])) &&
                     (chain_q[PU] == $past(core_pud[p])));

    assert_extest_R7: assert property (@(posedge tck) disable iff (!rst_n)
      extest_on |-> (pin_out[p] == upd_q[PD]) && (pin_oe[p] == upd_q[PE]) &&
                    (pin_pud[p] == upd_q[PU]) && (core_in[p] == upd_q[PI]));

    assert_func_R6: assert property (@(posedge tck) disable iff (!rst_n)
      !extest_on |-> (pin_out[p] == core_out[p]) && (pin_oe[p] == core_oe[p]) &&
                     (pin_pud[p] == core_pud[p]) && (core_in[p] == pin_in[p]));
  end
endmodule

bind bsr_chain bsr_chain_chk #(.NPINS(NPINS)) chk_i (.*);

// File: tb/bsr_chain_tb.sv
`timescale 1ns/1ps
module bsr_chain_tb_top;
  localparam int NP  = 4;
  localparam int LEN = NP * 4;

  logic tck = 1'b0;
  logic rst_n, tdi, shift_en, capture_en, update_en;
  logic [1:0] mode;
  logic [NP-1:0] core_out, core_oe, core_pud, pin_in;
  wire  tdo;
  wire  [NP-1:0] core_in, pin_out, pin_oe, pin_pud;

  int checks = 0;
  int fails  = 0;
  logic [LEN-1:0] m_sr, m_upd;

  bsr_chain #(.NPINS(NP)) dut_i (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .tdo(tdo),
    .shift_en(shift_en), .capture_en(capture_en), .update_en(update_en),
    .mode(mode), .core_out(core_out), .core_oe(core_oe), .core_pud(core_pud),
    .core_in(core_in), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_pud(pin_pud)
  );

  always #2.5 tck = ~tck;

  function automatic int slot(int p, int k);
    return LEN - 4 * (p + 1) + k;
  endfunction

  function automatic logic src_bit(int pos);
    int p = NP - 1 - pos / 4;
    case (pos % 4)
      0:       return pin_in[p];
      1:       return core_out[p];
      2:       return core_oe[p];
      default: return core_pud[p];
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(string ctag, string ptag);
    chk(ctag, {31'd0, tdo}, {31'd0, m_sr[LEN-1]});
    for (int p = 0; p < NP; p++) begin
      logic ext = (mode == 2'b10);
      chk(ptag, {28'd0, pin_out[p], pin_oe[p], pin_pud[p], core_in[p]},
          ext ? {28'd0, m_upd[slot(p,1)], m_upd[slot(p,2)], m_upd[slot(p,3)], m_upd[slot(p,0)]}
              : {28'd0, core_out[p], core_oe[p], core_pud[p], pin_in[p]});
    end
  endtask

  task automatic cyc(bit s, bit c, bit u, bit t);
    string ct, pt;
    shift_en = s; capture_en = c; update_en = u; tdi = t;
    @(negedge tck);
    if (u) m_upd = m_sr;
    @(posedge tck);
    if (c) begin
      for (int i = 0; i < LEN; i++) m_sr[i] = src_bit(i);
    end else if (s) m_sr = {m_sr[LEN-2:0], t};
    #1;
    ct = c ? "R3" : (s ? "R1" : "R4");
    pt = (mode == 2'b10) ? (u ? "R5" : "R7") : "R6";
    compare_all(ct, pt);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1149));
    rst_n = 1'b1; tdi = 0; shift_en = 0; capture_en = 0; update_en = 0;
    mode = 2'b10; core_out = '1; core_oe = '1; core_pud = '1; pin_in = '1;
    #1 rst_n = 1'b0;
    m_sr = '0; m_upd = '0;
    repeat (3) @(posedge tck);
    #1;
    chk("R8", {28'd0, pin_oe}, 32'd0);
    chk("R8", {31'd0, tdo}, 32'd0);
    chk("R8", {28'd0, pin_out}, 32'd0);
    rst_n = 1'b1;

    // R2: capture a known pattern and read it back in chain order
    mode = 2'b00; core_out = 4'b1010; core_oe = 4'b0110; core_pud = 4'b0011; pin_in = 4'b1001;
    cyc(0, 1, 0, 0);
    for (int j = 0; j < LEN; j++) begin
      chk("R2", {31'd0, tdo}, {31'd0, src_bit(LEN - 1 - j)});
      cyc(1, 0, 0, 1'b0);
    end

    // R3: capture and shift together, capture wins
    core_out = 4'b0101; pin_in = 4'b1100;
    cyc(1, 1, 0, 1);
    // R5 then R7: preload in sample mode, pins unaffected, then extest shows latches
    mode = 2'b01;
    cyc(0, 0, 1, 0);
    mode = 2'b10; #0.1;
    compare_all("R4", "R7");

    // R4: idle cycles keep the chain
    repeat (3) cyc(0, 0, 0, 1);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      mode     = 2'($urandom % 4);
      core_out = NP'($urandom); core_oe = NP'($urandom);
      core_pud = NP'($urandom); pin_in  = NP'($urandom);
      cyc(1'($urandom % 2), 1'(($urandom % 5) == 0), 1'(($urandom % 3) == 0), 1'($urandom));
    end

    summary();
    $finish;
  end
endmodule